// File: doc/BRIEF.md
# E3 Maintenance Byte Monitor

This block watches the maintenance-and-adaptation byte that the receive framer pulls out of every incoming E3 frame in the G.832 layout. For each frame it presents the byte together with a one-cycle strobe. The monitor does three things with that byte:

- It latches the payload type field and compares it with an expected value that software programs. When they differ it raises an interrupt pulse.
- It turns the far-end receive failure (RDI) bit into a defect flag that only changes after the new value has persisted.
- It turns the timing marker bit into a validated value in the same way.

For both persistence filters, a select input chooses a short or a long persistence window.

The monitor sits between the framer's overhead extraction and the alarm/status logic. Frame alignment, the other overhead bytes and register access are handled elsewhere. All outputs are registered and change only on the clock edge that samples a frame strobe, except where a select input changes.

Top module: `e3ma_monitor`

## Requirements
- R1: The maintenance byte is decoded with its most significant bit (bit 7) as the RDI bit, bits 5:3 as the payload type, and bit 0 as the timing marker. Bit 6 (remote error) and bits 2:1 (multiframe indicator) are ignored and never affect any output.
- R2: After synchronous active-high reset, the following hold:
  - `pt_received` is 3'b010.
  - `pt_mismatch`, `rdi_defect`, `tm_valid`, `pt_mismatch_irq`, `rdi_change` and `tm_change` are all 0.
- R3: On every frame strobe, `pt_received` takes the payload type of that frame, visible one clock later. It does not change without a strobe.
- R4: On every frame strobe, `pt_mismatch` becomes 1 if the received payload type differs from `pt_expected`, and 0 if it equals it.
- R5: `pt_mismatch_irq` is a single-cycle pulse on the first mismatching frame. Further mismatching frames give no pulse until a matching frame has been received, which re-arms it.
- R6: With `rdi_long_sel`=0, `rdi_defect` rises after the RDI bit is 1 in 3 consecutive frames. It falls after the bit is 0 in 3 consecutive frames.
- R7: With `rdi_long_sel`=1, both declaration and clearance of `rdi_defect` need 5 consecutive frames.
- R8: `tm_valid` takes a new timing marker value once that value is seen in 3 consecutive frames (`tm_long_sel`=0) or 5 consecutive frames (`tm_long_sel`=1).
- R9: A frame that carries the currently filtered value restarts the persistence count. The count then begins again from the next frame that differs.
- R10: Any change of `rdi_long_sel` or `tm_long_sel` restarts both persistence counters.
- R11: `rdi_change` and `tm_change` pulse for exactly one cycle, in the cycle where `rdi_defect` or `tm_valid` respectively takes a new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ma_valid | input | 1 | One-cycle strobe, one per received frame |
| ma_byte | input | 8 | Maintenance byte of the current frame |
| rdi_long_sel | input | 1 | RDI persistence: 0 = 3 frames, 1 = 5 frames |
| tm_long_sel | input | 1 | Timing marker persistence: 0 = 3 frames, 1 = 5 frames |
| pt_expected | input | 3 | Expected payload type |
| pt_received | output | 3 | Payload type of the latest frame |
| pt_mismatch | output | 1 | Latest frame's payload type differs from expected |
| pt_mismatch_irq | output | 1 | One-cycle pulse on a new payload type mismatch |
| rdi_defect | output | 1 | Filtered RDI defect |
| rdi_change | output | 1 | One-cycle pulse when `rdi_defect` changes |
| tm_valid | output | 1 | Validated timing marker |
| tm_change | output | 1 | One-cycle pulse when `tm_valid` changes |

## Verification
The bench checks the defect flag on the frame just before each threshold and on the threshold frame itself, for both persistence settings. A counter that is off by one would therefore declare one frame early or one frame late.

It breaks a run of RDI frames with a single clear frame, and also switches the window select in the middle of a run. A filter that fails to restart in either case would raise the defect too early.

For the interrupt, it sends repeated mismatching frames and then a matching frame. A design that pulses on every mismatching frame, or never re-arms, fails there.

It also toggles the ignored remote error and multiframe bits, to catch a wrong bit assignment.

// File: rtl/e3ma_pkg.sv
package e3ma_pkg;

    localparam int MA_W       = 8;
    localparam int PT_W       = 3;
    localparam int SHORT_N    = 3;
    localparam int LONG_N     = 5;
    localparam int N_FILT     = 2;

    // Bit positions inside the maintenance byte (bit 7 is sent first)
    localparam int POS_RDI    = 7;
    localparam int POS_REI    = 6;
    localparam int POS_PT_HI  = 5;
    localparam int POS_PT_LO  = 3;
    localparam int POS_MI_HI  = 2;
    localparam int POS_MI_LO  = 1;
    localparam int POS_TM     = 0;

    localparam logic [PT_W-1:0] PT_RESET = 3'b010;

    typedef enum logic [0:0] {
        FILT_RDI = 1'b0,
        FILT_TM  = 1'b1
    } filt_id_e;

    typedef struct packed {
        logic            rdi;
        logic [PT_W-1:0] pt;
        logic            tm;
        logic            spare;   // OR-reduced ignored bits
    } ma_fields_t;

    function automatic ma_fields_t ma_decode(input logic [MA_W-1:0] b);
        ma_fields_t f;
        f.rdi   = b[POS_RDI];
        f.pt    = b[POS_PT_HI:POS_PT_LO];
        f.tm    = b[POS_TM];
        f.spare = b[POS_REI] | (|b[POS_MI_HI:POS_MI_LO]);
        return f;
    endfunction

endpackage

// File: rtl/e3ma_persist_filter.sv
module e3ma_persist_filter #(
    parameter int SHORT_N = 3,
    parameter int LONG_N  = 5,
    localparam int CNT_W  = $clog2(LONG_N + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_vld,
    input  logic sample,
    input  logic long_sel,
    input  logic restart,
    output logic filt,
    output logic chg
);
    localparam logic [CNT_W-1:0] THR_S = CNT_W'(SHORT_N);
    localparam logic [CNT_W-1:0] THR_L = CNT_W'(LONG_N);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_base;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] thr;

    always_comb begin
        thr      = long_sel ? THR_L : THR_S;
        cnt_base = restart ? '0 : cnt;
        cnt_inc  = cnt_base + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= 1'b0;
            chg  <= 1'b0;
            cnt  <= '0;
        end else begin
            chg <= 1'b0;
            cnt <= cnt_base;
            if (frame_vld) begin
                if (sample == filt) begin
                    cnt <= '0;
                end else if (cnt_inc >= thr) begin
                    filt <= sample;
                    chg  <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt_inc;
                end
            end
        end
    end
endmodule

// File: rtl/e3ma_pt_check.sv
module e3ma_pt_check
    import e3ma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_vld,
    input  logic [PT_W-1:0] pt_in,
    input  logic [PT_W-1:0] pt_exp,
    output logic [PT_W-1:0] pt_cap,
    output logic            mism,
    output logic            irq
);
    logic armed;
    logic differs;

    always_comb differs = (pt_in != pt_exp);

    always_ff @(posedge clk) begin
        if (rst) begin
            pt_cap <= PT_RESET;
            mism   <= 1'b0;
            irq    <= 1'b0;
            armed  <= 1'b1;
        end else begin
            irq <= 1'b0;
            if (frame_vld) begin
                pt_cap <= pt_in;
                mism   <= differs;
                if (differs) begin
                    if (armed) begin
                        irq   <= 1'b1;
                        armed <= 1'b0;
                    end
                end else begin
                    armed <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/e3ma_monitor.sv
module e3ma_monitor
    import e3ma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ma_valid,
    input  logic [MA_W-1:0] ma_byte,
    input  logic            rdi_long_sel,
    input  logic            tm_long_sel,
    input  logic [PT_W-1:0] pt_expected,
    output logic [PT_W-1:0] pt_received,
    output logic            pt_mismatch,
    output logic            pt_mismatch_irq,
    output logic            rdi_defect,
    output logic            rdi_change,
    output logic            tm_valid,
    output logic            tm_change
);
    ma_fields_t       fields;
    logic             ma_unused_bits;
    logic [N_FILT-1:0] f_sample, f_sel, f_out, f_chg;
    logic             rdi_sel_q, tm_sel_q, sel_restart;

    always_comb begin
        fields         = ma_decode(ma_byte);
        ma_unused_bits = fields.spare;
    end

    // Any select change restarts both counters
    always_ff @(posedge clk) begin
        if (rst) begin
            rdi_sel_q <= 1'b0;
            tm_sel_q  <= 1'b0;
        end else begin
            rdi_sel_q <= rdi_long_sel;
            tm_sel_q  <= tm_long_sel;
        end
    end

    always_comb begin
        sel_restart       = (rdi_long_sel != rdi_sel_q) || (tm_long_sel != tm_sel_q);
        f_sample[FILT_RDI] = fields.rdi;
        f_sample[FILT_TM]  = fields.tm;
        f_sel[FILT_RDI]    = rdi_long_sel;
        f_sel[FILT_TM]     = tm_long_sel;
    end

    for (genvar g = 0; g < N_FILT; g++) begin : g_filt
        e3ma_persist_filter #(
            .SHORT_N(SHORT_N),
            .LONG_N (LONG_N)
        ) filt_i (
            .clk      (clk),
            .rst      (rst),
            .frame_vld(ma_valid),
            .sample   (f_sample[g]),
            .long_sel (f_sel[g]),
            .restart  (sel_restart),
            .filt     (f_out[g]),
            .chg      (f_chg[g])
        );
    end

    e3ma_pt_check pt_i (
        .clk      (clk),
        .rst      (rst),
        .frame_vld(ma_valid),
        .pt_in    (fields.pt),
        .pt_exp   (pt_expected),
        .pt_cap   (pt_received),
        .mism     (pt_mismatch),
        .irq      (pt_mismatch_irq)
    );

    assign rdi_defect = f_out[FILT_RDI];
    assign rdi_change = f_chg[FILT_RDI];
    assign tm_valid   = f_out[FILT_TM];
    assign tm_change  = f_chg[FILT_TM];
endmodule

// File: rtl/e3ma_monitor_chk.sv
module e3ma_monitor_chk
    import e3ma_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ma_valid,
    input logic [PT_W-1:0] pt_received,
    input logic            pt_mismatch,
    input logic            pt_mismatch_irq,
    input logic            rdi_defect,
    input logic            rdi_change,
    input logic            tm_valid,
    input logic            tm_change
);
    assert_pt_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(ma_valid) |-> $stable(pt_received));

    assert_irq_after_frame_R5: assert property (@(posedge clk) disable iff (rst)
        pt_mismatch_irq |-> ($past(ma_valid) && pt_mismatch));

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
        pt_mismatch_irq |=> !pt_mismatch_irq);

    assert_rdi_frame_only_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(ma_valid) |-> $stable(rdi_defect));

    assert_tm_frame_only_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(ma_valid) |-> $stable(tm_valid));

    assert_rdi_chg_match_R11: assert property (@(posedge clk) disable iff (rst)
        rdi_change == (rdi_defect != $past(rdi_defect)));

    assert_tm_chg_match_R11: assert property (@(posedge clk) disable iff (rst)
        tm_change == (tm_valid != $past(tm_valid)));
endmodule

bind e3ma_monitor e3ma_monitor_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .ma_valid       (ma_valid),
    .pt_received    (pt_received),
    .pt_mismatch    (pt_mismatch),
    .pt_mismatch_irq(pt_mismatch_irq),
    .rdi_defect     (rdi_defect),
    .rdi_change     (rdi_change),
    .tm_valid       (tm_valid),
    .tm_change      (tm_change)
);

// File: tb/e3ma_monitor_tb_top.sv
`timescale 1ns/1ps
module e3ma_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ma_valid = 1'b0;
    logic [7:0] ma_byte = 8'h00;
    logic       rdi_long_sel = 1'b0;
    logic       tm_long_sel = 1'b0;
    logic [2:0] pt_expected = 3'b010;
    logic [2:0] pt_received;
    logic       pt_mismatch, pt_mismatch_irq;
    logic       rdi_defect, rdi_change, tm_valid, tm_change;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    e3ma_monitor dut_i (
        .clk(clk), .rst(rst), .ma_valid(ma_valid), .ma_byte(ma_byte),
        .rdi_long_sel(rdi_long_sel), .tm_long_sel(tm_long_sel),
        .pt_expected(pt_expected), .pt_received(pt_received),
        .pt_mismatch(pt_mismatch), .pt_mismatch_irq(pt_mismatch_irq),
        .rdi_defect(rdi_defect), .rdi_change(rdi_change),
        .tm_valid(tm_valid), .tm_change(tm_change)
    );

    function automatic logic [7:0] mk(input logic rdi, input logic rei,
                                      input logic [2:0] pt, input logic [1:0] mi,
                                      input logic tm);
        return {rdi, rei, pt, mi, tm};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one frame; on return outputs reflect it (sampled at negedge)
    task automatic frame(input logic [7:0] b);
        @(negedge clk);
        ma_valid = 1'b1;
        ma_byte  = b;
        @(negedge clk);
        ma_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rdi_long_sel = 1'b0;
        tm_long_sel  = 1'b0;
        pt_expected  = 3'b010;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R2 pt_received", pt_received, 2);
        chk("R2 pt_mismatch", pt_mismatch, 0);
        chk("R2 rdi_defect", rdi_defect, 0);
        chk("R2 tm_valid", tm_valid, 0);
        chk("R2 irq", pt_mismatch_irq, 0);
        chk("R2 changes", {rdi_change, tm_change}, 0);
    endtask

    task automatic t_payload();
        do_reset();
        frame(mk(0, 0, 3'b101, 2'b00, 0));
        chk("R3 capture", pt_received, 5);
        chk("R4 mismatch", pt_mismatch, 1);
        chk("R5 first irq", pt_mismatch_irq, 1);
        @(negedge clk);
        chk("R5 one cycle", pt_mismatch_irq, 0);
        chk("R3 hold", pt_received, 5);
        frame(mk(0, 0, 3'b111, 2'b00, 0));
        chk("R3 capture2", pt_received, 7);
        chk("R5 no repeat", pt_mismatch_irq, 0);
        frame(mk(0, 0, 3'b010, 2'b00, 0));
        chk("R4 match", pt_mismatch, 0);
        chk("R5 no irq on match", pt_mismatch_irq, 0);
        frame(mk(0, 0, 3'b101, 2'b00, 0));
        chk("R5 rearmed", pt_mismatch_irq, 1);
        pt_expected = 3'b101;
        frame(mk(0, 0, 3'b101, 2'b00, 0));
        chk("R4 new expected", pt_mismatch, 0);
    endtask

    // n frames of the RDI bit; check defect before and at the threshold
    task automatic t_rdi(input logic long_sel, input int n);
        do_reset();
        rdi_long_sel = long_sel;
        repeat (2) @(negedge clk);
        for (int i = 1; i < n; i++) frame(mk(1, 0, 3'b010, 2'b00, 0));
        chk(long_sel ? "R7 not yet" : "R6 not yet", rdi_defect, 0);
        frame(mk(1, 0, 3'b010, 2'b00, 0));
        chk(long_sel ? "R7 declare" : "R6 declare", rdi_defect, 1);
        chk("R11 rdi_change", rdi_change, 1);
        @(negedge clk);
        chk("R11 rdi_change one cycle", rdi_change, 0);
        for (int i = 1; i < n; i++) frame(mk(0, 0, 3'b010, 2'b00, 0));
        chk(long_sel ? "R7 still set" : "R6 still set", rdi_defect, 1);
        frame(mk(0, 0, 3'b010, 2'b00, 0));
        chk(long_sel ? "R7 clear" : "R6 clear", rdi_defect, 0);
        chk("R11 rdi_change clear", rdi_change, 1);
    endtask

    task automatic t_tm(input logic long_sel, input int n);
        do_reset();
        tm_long_sel = long_sel;
        repeat (2) @(negedge clk);
        for (int i = 1; i < n; i++) frame(mk(0, 0, 3'b010, 2'b00, 1));
        chk("R8 tm not yet", tm_valid, 0);
        frame(mk(0, 0, 3'b010, 2'b00, 1));
        chk("R8 tm validated", tm_valid, 1);
        chk("R11 tm_change", tm_change, 1);
        chk("R8 rdi untouched", rdi_defect, 0);
    endtask

    task automatic t_interrupt();
        do_reset();
        frame(mk(1, 0, 3'b010, 2'b00, 0));
        frame(mk(1, 0, 3'b010, 2'b00, 0));
        frame(mk(0, 0, 3'b010, 2'b00, 0));
        frame(mk(1, 0, 3'b010, 2'b00, 0));
        frame(mk(1, 0, 3'b010, 2'b00, 0));
        chk("R9 restart after gap", rdi_defect, 0);
        frame(mk(1, 0, 3'b010, 2'b00, 0));
        chk("R9 declare after restart", rdi_defect, 1);
    endtask

    task automatic t_sel_change();
        do_reset();
        frame(mk(1, 0, 3'b010, 2'b00, 1));
        frame(mk(1, 0, 3'b010, 2'b00, 1));
        @(negedge clk); tm_long_sel = 1'b1;
        @(negedge clk); tm_long_sel = 1'b0;
        @(negedge clk);
        frame(mk(1, 0, 3'b010, 2'b00, 1));
        frame(mk(1, 0, 3'b010, 2'b00, 1));
        chk("R10 rdi restarted", rdi_defect, 0);
        chk("R10 tm restarted", tm_valid, 0);
        frame(mk(1, 0, 3'b010, 2'b00, 1));
        chk("R10 rdi declare", rdi_defect, 1);
        chk("R10 tm validate", tm_valid, 1);
    endtask

    task automatic t_ignored();
        do_reset();
        for (int i = 0; i < 6; i++)
            frame(mk(0, 1'(i), 3'b010, 2'(i + 1), 0));
        chk("R1 rei/mi no rdi", rdi_defect, 0);
        chk("R1 rei/mi no tm", tm_valid, 0);
        chk("R1 pt field", pt_received, 2);
        chk("R1 no mismatch", pt_mismatch, 0);
        frame(8'b0011_1000);
        chk("R1 pt bits 5:3", pt_received, 7);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_payload();
        t_rdi(1'b0, 3);
        t_rdi(1'b1, 5);
        t_tm(1'b0, 3);
        t_tm(1'b1, 5);
        t_interrupt();
        t_sel_change();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule